// File: doc/BRIEF.md
# Synchronous Burst Flash Read Sequencer

This block carries read requests from an on-chip requester to an external flash device. A request holds a start word address and a beat count. The block drives the external address. In synchronous mode it also drives a one-cycle load strobe (`lba_o`), a burst clock (`bclk_o`) and an end-of-burst marker (`eob_o`). It samples the external data bus and returns each word on `rdata_o` with `rvalid_o`. After the last word it pulses `done_o` for one cycle.

The configuration inputs are captured when a request is accepted:
- a synchronous-mode enable;
- a page-emulation enable;
- a continuous-clock override;
- a 4-bit clock-start delay;
- a 2-bit page size;
- a 4-bit data-latency code.

In synchronous mode the block splits a burst at page boundaries. At each boundary it issues a fresh load strobe and address. With synchronous mode off, or with page emulation on, every word is a plain asynchronous access: the address is driven for `ASYNC_CYC` clocks and the burst pins stay low.

One burst-clock half period equals one system clock. A word address counts port-width words.

Top module: `burst_rd_seq`

## Requirements
- R1: After reset, every output is 0 and stays 0 until a request is accepted.
- R2: `req_valid_i` is accepted only while the block is idle and `req_len_i` is non-zero. A request made while busy, or one with length 0, has no effect: it produces no word and no `done_o`.
- R3: Asynchronous mode applies when `cfg_sync_en_i`=0. Word k (k=0..len-1) is read by driving `addr_o` = start+k for `ASYNC_CYC` clocks. `ext_data_i` is sampled at the end of the last of those clocks. `lba_o`, `bclk_o` and `eob_o` stay 0 throughout.
- R4: In asynchronous mode the data-latency code has no effect. A request of len words takes the same time for every code: `done_o` is high in cycle len·ASYNC_CYC+1, where cycle 0 is the first cycle after the accepting edge.
- R5: In synchronous mode each segment starts with `lba_o` high for exactly one cycle, with `addr_o` holding the segment's first address. The first rising edge of `bclk_o` comes n+1 cycles after the start of that cycle, where n is `cfg_clk_start_i` (0..15). `bclk_o` is never high together with `lba_o`.
- R6: With `cfg_cont_bclk_i`=1 the clock-start field is ignored, and `bclk_o` rises in the cycle right after `lba_o`.
- R7: The data-latency code c gives D clocks per word: D=2 for codes 0 and 1, and D=c+1 otherwise. For each word, `bclk_o` is high for one cycle and then low for D-1 cycles. `ext_data_i` is sampled at the end of the last low cycle.
- R8: Page size code p gives 4·2^p words per page (0→4, 1→8, 2→16, 3→32). A synchronous burst never runs past a page boundary. It is split into segments, each opened with its own `lba_o` pulse.
- R9: With `cfg_sync_en_i`=1 and `cfg_page_emu_i`=1, the block behaves exactly as in R3: one address per word, burst pins low, and the latency and start fields ignored.
- R10: In synchronous mode `eob_o` is high during every cycle of the final word of the request, and low otherwise.
- R11: Each sampled word appears on `rdata_o` with `rvalid_o` in the next cycle, with words in address order. `done_o` is high for exactly one cycle, the cycle after the last `rvalid_o`.
- R12: Configuration inputs are captured at acceptance. Changing them during a request does not change its timing or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe |
| req_addr_i | input | AW | Start word address |
| req_len_i | input | LW | Number of words |
| cfg_sync_en_i | input | 1 | Synchronous burst mode enable |
| cfg_page_emu_i | input | 1 | Page-mode emulation enable |
| cfg_cont_bclk_i | input | 1 | Continuous burst clock override |
| cfg_clk_start_i | input | 4 | Burst clock start delay code |
| cfg_page_sz_i | input | 2 | Page size code |
| cfg_data_len_i | input | 4 | Data latency code |
| rdata_o | output | DW | Returned word |
| rvalid_o | output | 1 | Returned word valid |
| done_o | output | 1 | Request complete pulse |
| addr_o | output | AW | External address |
| lba_o | output | 1 | Load burst address strobe |
| bclk_o | output | 1 | Burst clock |
| eob_o | output | 1 | End of burst marker |
| ext_data_i | input | DW | External read data |

## Verification
A wrong start delay or latency decode moves the first `bclk_o` edge and the sample point. The flash model then returns a poison word, so the error shows as bad data on the first `rvalid_o`, and `done_o` comes in the wrong cycle. A wrong segment length or page split shows up as a wrong count of `lba_o` pulses, and as data from the wrong address within the first page crossing. A corrupted word counter shows up as an extra word, a missing word or a misplaced `eob_o` at the end of that same request. A mode bit captured wrongly shows up in the request's first cycle, through burst pins toggling in asynchronous mode.

// File: rtl/bfl_pkg.sv
package bfl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LBA, ST_WAIT, ST_BEAT, ST_ASY, ST_DRAIN, ST_DONE
  } st_e;

  // words per page from page size code
  function automatic logic [5:0] page_words(input logic [1:0] psz);
    return 6'd4 << psz;
  endfunction

  // clocks per beat minus one
  function automatic logic [3:0] lat_m1(input logic [3:0] code);
    return (code < 4'd2) ? 4'd1 : code;
  endfunction
endpackage

// File: rtl/bfl_cfg_decode.sv
module bfl_cfg_decode (
  input  logic       sync_en_i,
  input  logic       page_emu_i,
  input  logic       cont_bclk_i,
  input  logic [3:0] clk_start_i,
  input  logic [3:0] data_len_i,
  output logic       sync_mode_o,
  output logic [3:0] wait_cyc_o,
  output logic [3:0] lat_m1_o
);
  import bfl_pkg::*;
  assign sync_mode_o = sync_en_i & ~page_emu_i;
  assign wait_cyc_o  = cont_bclk_i ? 4'd0 : clk_start_i;
  assign lat_m1_o    = lat_m1(data_len_i);
endmodule

// File: rtl/bfl_seg_calc.sv
module bfl_seg_calc #(
  parameter int AW = 24,
  parameter int LW = 6
) (
  input  logic [AW-1:0] addr_i,
  input  logic [LW-1:0] left_i,
  input  logic [1:0]    psz_i,
  output logic [LW-1:0] seg_o
);
  import bfl_pkg::*;
  localparam int XW = (LW > 6) ? LW + 1 : 7;
  logic [5:0]    words;
  logic [XW-1:0] off, room, left_x;

  always_comb begin
    words  = page_words(psz_i);
    off    = XW'(addr_i[4:0] & (words[4:0] - 5'd1));
    if (words == 6'd32) off = XW'(addr_i[4:0]);
    room   = XW'(words) - off;
    left_x = XW'(left_i);
    seg_o  = (left_x < room) ? left_i : LW'(room);
  end
endmodule

// File: rtl/burst_rd_seq.sv
module burst_rd_seq #(
  parameter int AW        = 24,
  parameter int DW        = 16,
  parameter int LW        = 6,
  parameter int ASYNC_CYC = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [LW-1:0] req_len_i,
  input  logic          cfg_sync_en_i,
  input  logic          cfg_page_emu_i,
  input  logic          cfg_cont_bclk_i,
  input  logic [3:0]    cfg_clk_start_i,
  input  logic [1:0]    cfg_page_sz_i,
  input  logic [3:0]    cfg_data_len_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o,
  output logic          done_o,
  output logic [AW-1:0] addr_o,
  output logic          lba_o,
  output logic          bclk_o,
  output logic          eob_o,
  input  logic [DW-1:0] ext_data_i
);
  import bfl_pkg::*;
  localparam int CW = (ASYNC_CYC > 16) ? $clog2(ASYNC_CYC) : 4;
  localparam logic [CW-1:0] ASY_LAST = CW'(ASYNC_CYC - 1);

  st_e           st_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] addr_q, seg_addr_q;
  logic [LW-1:0] left_q, seg_q, seg_len;
  logic          sync_act_q;
  logic [3:0]    wait_q, lat_q;
  logic [1:0]    psz_q;
  logic [DW-1:0] rdata_q;
  logic          rvalid_q;
  logic          dec_sync;
  logic [3:0]    dec_wait, dec_lat;
  logic          accept, sample;

  bfl_cfg_decode u_dec (
    .sync_en_i   (cfg_sync_en_i),
    .page_emu_i  (cfg_page_emu_i),
    .cont_bclk_i (cfg_cont_bclk_i),
    .clk_start_i (cfg_clk_start_i),
    .data_len_i  (cfg_data_len_i),
    .sync_mode_o (dec_sync),
    .wait_cyc_o  (dec_wait),
    .lat_m1_o    (dec_lat)
  );

  bfl_seg_calc #(.AW(AW), .LW(LW)) u_seg (
    .addr_i (addr_q),
    .left_i (left_q),
    .psz_i  (psz_q),
    .seg_o  (seg_len)
  );

  assign accept = (st_q == ST_IDLE) && req_valid_i && (req_len_i != '0);
  assign sample = ((st_q == ST_BEAT) && (cnt_q == CW'(lat_q))) ||
                  ((st_q == ST_ASY)  && (cnt_q == ASY_LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      addr_q     <= '0;
      seg_addr_q <= '0;
      left_q     <= '0;
      seg_q      <= '0;
      sync_act_q <= 1'b0;
      wait_q     <= '0;
      lat_q      <= '0;
      psz_q      <= '0;
      rdata_q    <= '0;
      rvalid_q   <= 1'b0;
    end else begin
      rvalid_q <= sample;
      if (sample) rdata_q <= ext_data_i;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          addr_q     <= req_addr_i;
          seg_addr_q <= req_addr_i;
          left_q     <= req_len_i;
          sync_act_q <= dec_sync;
          wait_q     <= dec_wait;
          lat_q      <= dec_lat;
          psz_q      <= cfg_page_sz_i;
          cnt_q      <= '0;
          st_q       <= dec_sync ? ST_LBA : ST_ASY;
        end
        ST_LBA: begin
          seg_q <= seg_len;
          if (wait_q == 4'd0) begin
            cnt_q <= '0;
            st_q  <= ST_BEAT;
          end else begin
            cnt_q <= CW'(wait_q);
            st_q  <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (cnt_q == CW'(1)) begin
            cnt_q <= '0;
            st_q  <= ST_BEAT;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        ST_BEAT: begin
          if (sample) begin
            addr_q <= addr_q + AW'(1);
            left_q <= left_q - LW'(1);
            seg_q  <= seg_q - LW'(1);
            cnt_q  <= '0;
            if (left_q == LW'(1)) begin
              st_q <= ST_DRAIN;
            end else if (seg_q == LW'(1)) begin
              seg_addr_q <= addr_q + AW'(1);
              st_q       <= ST_LBA;
            end
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        ST_ASY: begin
          if (sample) begin
            cnt_q  <= '0;
            left_q <= left_q - LW'(1);
            if (left_q == LW'(1)) st_q <= ST_DRAIN;
            else addr_q <= addr_q + AW'(1);
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        ST_DRAIN: st_q <= ST_DONE;
        ST_DONE:  st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign addr_o   = (st_q == ST_ASY) ? addr_q : seg_addr_q;
  assign lba_o    = (st_q == ST_LBA);
  assign bclk_o   = (st_q == ST_BEAT) && (cnt_q == '0);
  assign eob_o    = (st_q == ST_BEAT) && (left_q == LW'(1));
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign done_o   = (st_q == ST_DONE);
endmodule

// File: rtl/bfl_chk.sv
module bfl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic lba_o,
  input logic bclk_o,
  input logic eob_o,
  input logic rvalid_o,
  input logic done_o,
  input logic sync_act
);
  AST_LBA_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lba_o |=> !lba_o); // R5
  AST_NO_BCLK_AT_LBA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lba_o |-> !bclk_o); // R5
  AST_BCLK_HIGH_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bclk_o |=> !bclk_o); // R7
  AST_ASYNC_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_act |-> (!lba_o && !bclk_o && !eob_o)); // R3
  AST_DONE_AFTER_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(rvalid_o)); // R11
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
  AST_NO_VALID_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !rvalid_o); // R11
endmodule

bind burst_rd_seq bfl_chk u_bfl_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .lba_o    (lba_o),
  .bclk_o   (bclk_o),
  .eob_o    (eob_o),
  .rvalid_o (rvalid_o),
  .done_o   (done_o),
  .sync_act (sync_act_q)
);

// File: tb/tb_burst_rd_seq.sv
module tb_burst_rd_seq;
  localparam int AW = 24, DW = 16, LW = 6, A = 3;
  localparam time TCK = 20ns;

  logic clk = 0, rst_ni = 0;
  logic req_valid = 0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic sync_en = 0, page_emu = 0, cont_bclk = 0;
  logic [3:0] clk_start = 0, data_len = 0;
  logic [1:0] page_sz = 0;
  logic [DW-1:0] rdata, ext_data;
  logic rvalid, done, lba, bclk, eob;
  logic [AW-1:0] addr;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  // flash model state
  bit m_sync = 0;
  int m_d = 2;
  logic [AW-1:0] base, cur;
  int nb = 0, age = 0;

  // scoreboard
  logic [DW-1:0] q_data[$];
  bit            q_last[$];
  bit eob_prev = 0;
  int lba_cnt = 0;

  always #(TCK/2) clk = ~clk;

  burst_rd_seq #(.AW(AW), .DW(DW), .LW(LW), .ASYNC_CYC(A)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_len_i(req_len), .cfg_sync_en_i(sync_en), .cfg_page_emu_i(page_emu),
    .cfg_cont_bclk_i(cont_bclk), .cfg_clk_start_i(clk_start), .cfg_page_sz_i(page_sz),
    .cfg_data_len_i(data_len), .rdata_o(rdata), .rvalid_o(rvalid), .done_o(done),
    .addr_o(addr), .lba_o(lba), .bclk_o(bclk), .eob_o(eob), .ext_data_i(ext_data));

  function automatic logic [DW-1:0] fdat(input logic [AW-1:0] a);
    return {a[7:0] ^ 8'h5C, a[15:8] + a[7:0]};
  endfunction

  always @(posedge clk) begin
    if (lba) begin
      base <= addr; nb <= 0; age <= 0;
    end else if (bclk) begin
      cur <= base + AW'(nb); nb <= nb + 1; age <= 1;
    end else if (age < 100) age <= age + 1;
  end

  always_comb begin
    if (!m_sync) ext_data = fdat(addr);
    else if (!bclk && nb != 0 && age >= m_d - 1) ext_data = fdat(cur);
    else ext_data = 16'hDEAD;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_ni) begin
      if (lba) lba_cnt++;
      if (rvalid) begin
        if (q_data.size() == 0) chk(0, "R2 extra word", rdata, 0);
        else begin
          logic [DW-1:0] ed;
          bit el;
          ed = q_data.pop_front();
          el = q_last.pop_front();
          chk(rdata == ed, "R11 word data", rdata, ed);
          chk(eob_prev == el, "R10 eob on final beat", eob_prev, el);
        end
      end
      eob_prev = eob;
    end
  end

  task automatic run_req(input logic [AW-1:0] a, input int len, input bit se, input bit pe,
                         input bit cb, input int cs, input int ps, input int dl,
                         input bit perturb, input string tag);
    int words, h, d, t, segs, left, done_at, first_bclk;
    logic [AW-1:0] pa;
    bit sm;
    sm = se && !pe;
    words = 4 << ps;
    h = cb ? 1 : cs + 1;
    d = (dl < 2) ? 2 : dl + 1;
    t = 0; segs = 0; left = len; pa = a;
    while (left > 0) begin
      int room, b;
      room = words - int'(pa % AW'(words));
      b = (left < room) ? left : room;
      t += h + b * d; segs++; left -= b; pa += AW'(b);
    end
    if (!sm) t = len * A;
    for (int k = 0; k < len; k++) begin
      q_data.push_back(fdat(a + AW'(k)));
      q_last.push_back(sm && (k == len - 1));
    end
    @(negedge clk);
    m_sync = sm; m_d = d;
    sync_en = se; page_emu = pe; cont_bclk = cb;
    clk_start = 4'(cs); page_sz = 2'(ps); data_len = 4'(dl);
    req_addr = a; req_len = LW'(len); req_valid = 1;
    lba_cnt = 0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    done_at = -1; first_bclk = -1;
    for (int c = 0; c < 3000; c++) begin
      if (bclk && first_bclk < 0) first_bclk = c;
      if (done) begin done_at = c; break; end
      if (perturb && c == 3) begin
        sync_en = !se; data_len = 4'd15; clk_start = 4'd15; page_sz = 2'd3;
        req_valid = 1; req_addr = 24'h000777; req_len = 6'd9;
      end
      if (perturb && c == 4) req_valid = 0;
      @(negedge clk);
    end
    chk(done_at == t + 1, {tag, " done cycle"}, done_at, t + 1);
    if (sm) begin
      chk(lba_cnt == segs, "R8 lba pulses per page split", lba_cnt, segs);
      chk(first_bclk == h, "R5/R6 first bclk rise", first_bclk, h);
    end else begin
      chk(lba_cnt == 0 && first_bclk < 0, "R3/R9 burst pins idle", lba_cnt, 0);
    end
    repeat (4) @(negedge clk);
    chk(q_data.size() == 0, "R11 all words returned", q_data.size(), 0);
    q_data.delete(); q_last.delete();
  endtask

  initial begin
    #(TCK * 200000);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    repeat (3) @(negedge clk);
    chk({rvalid, done, lba, bclk, eob} == 5'b0 && rdata == '0 && addr == '0,
        "R1 reset outputs", {rvalid, done, lba, bclk, eob}, 0);
    // R3 plain async
    run_req(24'h000010, 5, 0, 0, 0, 0, 0, 0, 0, "R3 async");
    // R4 latency code ignored in async
    run_req(24'h000010, 5, 0, 0, 0, 0, 0, 15, 0, "R4 async latency ignored");
    // R5/R7 minimal delays
    run_req(24'h000020, 3, 1, 0, 0, 0, 0, 0, 0, "R5 sync bcs0");
    run_req(24'h000040, 4, 1, 0, 0, 5, 1, 1, 0, "R5 sync bcs5");
    // R6 continuous override
    run_req(24'h000048, 4, 1, 0, 1, 9, 1, 0, 0, "R6 continuous clock");
    // R7 long latency
    run_req(24'h000100, 3, 1, 0, 0, 2, 2, 7, 0, "R7 latency 8");
    run_req(24'h000200, 2, 1, 0, 0, 15, 2, 15, 0, "R7 latency 16");
    // R8 page splits
    run_req(24'h000006, 7, 1, 0, 0, 1, 0, 2, 0, "R8 page 4 split");
    run_req(24'h00001E, 5, 1, 0, 0, 0, 3, 0, 0, "R8 page 32 split");
    run_req(24'h00003D, 20, 1, 0, 0, 3, 2, 3, 0, "R8 page 16 split");
    // R9 emulation
    run_req(24'h000033, 6, 1, 1, 0, 3, 0, 9, 0, "R9 emulation");
    // R12 and R2: config change and request while busy
    run_req(24'h000050, 6, 1, 0, 0, 2, 0, 2, 1, "R12 sync cfg captured");
    run_req(24'h000060, 4, 0, 0, 0, 0, 0, 0, 1, "R12 async cfg captured");
    // R2 zero length ignored
    @(negedge clk);
    req_addr = 24'h000123; req_len = '0; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    begin
      bit seen;
      seen = 0;
      for (int c = 0; c < 30; c++) begin
        if (done || rvalid || lba || bclk) seen = 1;
        @(negedge clk);
      end
      chk(!seen, "R2 zero length ignored", seen, 0);
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule